// File: doc/BRIEF.md
# Multiplexed Dot-Matrix Refresh Controller

This block refreshes a row of 5x7 dot-matrix characters (four by default). It holds one byte per character: seven bits of character code and one attribute bit. It steps through the seven dot rows one at a time. For the active row it hands every character's code, together with the row number, to an outside pattern lookup. The lookup answers in the same cycle with five column bits per character. The block registers those bits, together with a one-hot row strobe, and sends them to the LED drivers.

Each row slot is split into four equal sub-slots, and a two-bit brightness code lights the columns for 4, 2, 1 or 0 of them. Characters whose attribute bit is set go dark during the off half of a blink cycle. The blink phase flips every 2^BLINK_LOG2 complete frames. A blank input darkens everything. A lamp-test input lights every dot and overrides blank, blink and brightness.

The scan advances on a tick, which comes from one of two sources. With the select input high, the tick comes from an internal divider and is also driven out so that other units can follow it. With the select input low, the tick comes from rising edges of an external clock after a synchronizer. A synchronous reset clears the divider, the synchronizer and the scan and blink counters, so that cascaded units stay in step. Reset does not touch the stored characters.

Top module: `dmx_refresh_ctrl`

## Requirements
- R1: While rst is high, row_out, col_out and tick_out are all zero, and the sub-slot, row, frame and divider counters return to zero. Characters already stored are kept and are shown again after reset is released.
- R2: After reset the active row follows the order 0,1,...,6 and then wraps to 0. Each row lasts exactly four ticks (sub-slots 0..3). row_out bit r is high only while row r is active, so at most one bit is ever high.
- R3: font_row carries the active row index, and font_code bits [7d+6:7d] carry bits [6:0] of character d. The five bits the lookup returns for character d on font_cols[5d+4:5d] appear on col_out[5d+4:5d] one clock later.
- R4: The brightness code bright lights the columns in these sub-slots: 3 in all four, 2 in sub-slots 0 and 1, 1 in sub-slot 0 only, and 0 in none (all columns dark).
- R5: A frame counter counts completed frames of seven rows. The blink phase is bit BLINK_LOG2 of that counter and is off while that bit is 1. During the off phase, the columns of every character whose stored bit 7 is set are forced to zero. Characters with bit 7 clear are unaffected.
- R6: When blank is high and lamp_test is low, col_out is all zero in the next cycle.
- R7: When lamp_test is high, col_out is all ones in the next cycle, whatever the values of blank, blink phase and brightness.
- R8: With clk_sel high, one tick occurs every INT_DIV clocks. tick_out pulses for one clock on each of these ticks.
- R9: With clk_sel low, each rising edge on ext_clk_in produces exactly one tick, three clocks after the edge is first sampled, and tick_out stays low.
- R10: A clock edge with wr_en high stores wr_data into character wr_addr. Bit 7 of the stored byte is the blink attribute and bits 6:0 are the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of counters and outputs |
| clk_sel | input | 1 | 1: internal tick (exported); 0: external tick |
| ext_clk_in | input | 1 | External time base, asynchronous |
| tick_out | output | 1 | One-clock pulse per internal tick |
| wr_en | input | 1 | Character write strobe |
| wr_addr | input | $clog2(NUM_DIGITS) | Character index to write |
| wr_data | input | 8 | Attribute bit 7, code bits 6:0 |
| bright | input | 2 | Brightness code 0..3 |
| blank | input | 1 | Force all columns dark |
| lamp_test | input | 1 | Force all columns lit |
| font_code | output | NUM_DIGITS*7 | Character codes to the pattern lookup |
| font_row | output | 3 | Active row to the pattern lookup |
| font_cols | input | NUM_DIGITS*5 | Column pattern returned by the lookup |
| row_out | output | 7 | One-hot row strobe |
| col_out | output | NUM_DIGITS*5 | Gated column drive |

## Verification
The assertions assume that the pattern lookup is purely combinational, with no latency, and that control inputs change only between clock edges. The bench meets both conditions: it models the lookup as an arithmetic function of code and row, and it drives every input on the falling edge. The external clock is assumed to stay at each level for at least two system clocks. The bench toggles it every three clocks and also holds it steady, so the single-tick-per-edge rule is exercised without glitches that the synchronizer would filter out.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int ROWS     = 7;
  localparam int COLS     = 5;
  localparam int CODE_W   = 7;
  localparam int BYTE_W   = 8;
  localparam int SUBSLOTS = 4;
  localparam int ROW_W    = 3;
  localparam int SUB_W    = 2;

  typedef enum logic [1:0] {
    BR_DARK    = 2'd0,
    BR_QUARTER = 2'd1,
    BR_HALF    = 2'd2,
    BR_FULL    = 2'd3
  } bright_e;

  // Is the given sub-slot lit for the given brightness step?
  function automatic logic slot_lit(input bright_e b, input logic [SUB_W-1:0] sub);
    logic lit;
    unique case (b)
      BR_FULL:    lit = 1'b1;
      BR_HALF:    lit = (sub < 2'd2);
      BR_QUARTER: lit = (sub == 2'd0);
      default:    lit = 1'b0;
    endcase
    return lit;
  endfunction
endpackage

// File: rtl/dmx_tick_src.sv
module dmx_tick_src #(
  parameter int INT_DIV = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_int,
  input  logic ext_in,
  output logic tick,
  output logic tick_export
);
  localparam int DW = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(INT_DIV - 1);

  logic [DW-1:0] div_q;
  logic [2:0]    sync_q;
  logic          div_hit;
  logic          ext_rise;

  assign div_hit  = (div_q == DIV_LAST);
  assign ext_rise = sync_q[1] & ~sync_q[2];

  // Internal divider, held at zero while the external source is in use
  always_ff @(posedge clk) begin
    if (rst || !sel_int) begin
      div_q <= '0;
    end else if (div_hit) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // Two-stage synchronizer plus one history stage for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], ext_in};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick        <= 1'b0;
      tick_export <= 1'b0;
    end else begin
      tick        <= sel_int ? div_hit : ext_rise;
      tick_export <= sel_int & div_hit;
    end
  end
endmodule

// File: rtl/dmx_scan_ctr.sv
module dmx_scan_ctr
  import dmx_pkg::*;
#(
  parameter int BLINK_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [ROW_W-1:0] row,
  output logic [SUB_W-1:0] sub,
  output logic             blink_off
);
  localparam int FW = BLINK_LOG2 + 1;
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUBSLOTS - 1);

  logic [FW-1:0] frame_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sub     <= '0;
      row     <= '0;
      frame_q <= '0;
    end else if (tick) begin
      if (sub == SUB_LAST) begin
        sub <= '0;
        if (row == ROW_LAST) begin
          row     <= '0;
          frame_q <= frame_q + 1'b1;
        end else begin
          row <= row + 1'b1;
        end
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  assign blink_off = frame_q[FW-1];
endmodule

// File: rtl/dmx_char_ram.sv
module dmx_char_ram
  import dmx_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int AW         = 2
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  logic [BYTE_W-1:0]            wr_data,
  output logic [NUM_DIGITS*CODE_W-1:0] codes,
  output logic [NUM_DIGITS-1:0]        attrs
);
  logic [BYTE_W-1:0] mem_q [NUM_DIGITS];

  // Storage has no reset on purpose: a counter reset must leave text intact
  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_addr) < NUM_DIGITS)) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_rd
    assign codes[d*CODE_W +: CODE_W] = mem_q[d][CODE_W-1:0];
    assign attrs[d]                  = mem_q[d][BYTE_W-1];
  end
endmodule

// File: rtl/dmx_col_gate.sv
module dmx_col_gate
  import dmx_pkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ROW_W-1:0]           row,
  input  logic [SUB_W-1:0]           sub,
  input  logic                       blink_off,
  input  logic [NUM_DIGITS-1:0]      attrs,
  input  logic [NUM_DIGITS*COLS-1:0] pattern,
  input  bright_e                    bright,
  input  logic                       blank,
  input  logic                       lamp_test,
  output logic [ROWS-1:0]            row_out,
  output logic [NUM_DIGITS*COLS-1:0] col_out
);
  logic                       lit;
  logic [NUM_DIGITS*COLS-1:0] col_next;

  assign lit = slot_lit(bright, sub);

  // Priority: lamp test, then blank, then brightness and blink gating
  always_comb begin
    for (int d = 0; d < NUM_DIGITS; d++) begin
      if (lamp_test) begin
        col_next[d*COLS +: COLS] = '1;
      end else if (blank || !lit || (attrs[d] && blink_off)) begin
        col_next[d*COLS +: COLS] = '0;
      end else begin
        col_next[d*COLS +: COLS] = pattern[d*COLS +: COLS];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_out <= '0;
      col_out <= '0;
    end else begin
      row_out <= ROWS'(1) << row;
      col_out <= col_next;
    end
  end
endmodule

// File: rtl/dmx_refresh_ctrl.sv
module dmx_refresh_ctrl
  import dmx_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int INT_DIV    = 1000,
  parameter int BLINK_LOG2 = 4,
  localparam int AW        = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clk_sel,
  input  logic                         ext_clk_in,
  output logic                         tick_out,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  logic [7:0]                   wr_data,
  input  logic [1:0]                   bright,
  input  logic                         blank,
  input  logic                         lamp_test,
  output logic [NUM_DIGITS*7-1:0]      font_code,
  output logic [2:0]                   font_row,
  input  logic [NUM_DIGITS*5-1:0]      font_cols,
  output logic [6:0]                   row_out,
  output logic [NUM_DIGITS*5-1:0]      col_out
);
  logic                  tick;
  logic [ROW_W-1:0]      row;
  logic [SUB_W-1:0]      sub;
  logic                  blink_off;
  logic [NUM_DIGITS-1:0] attrs;

  dmx_tick_src #(.INT_DIV(INT_DIV)) u_tick (
    .clk         (clk),
    .rst         (rst),
    .sel_int     (clk_sel),
    .ext_in      (ext_clk_in),
    .tick        (tick),
    .tick_export (tick_out)
  );

  dmx_scan_ctr #(.BLINK_LOG2(BLINK_LOG2)) u_scan (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .row       (row),
    .sub       (sub),
    .blink_off (blink_off)
  );

  dmx_char_ram #(.NUM_DIGITS(NUM_DIGITS), .AW(AW)) u_ram (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .codes   (font_code),
    .attrs   (attrs)
  );

  assign font_row = row;

  dmx_col_gate #(.NUM_DIGITS(NUM_DIGITS)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .row       (row),
    .sub       (sub),
    .blink_off (blink_off),
    .attrs     (attrs),
    .pattern   (font_cols),
    .bright    (bright_e'(bright)),
    .blank     (blank),
    .lamp_test (lamp_test),
    .row_out   (row_out),
    .col_out   (col_out)
  );
endmodule

// File: rtl/dmx_refresh_ctrl_chk.sv
module dmx_refresh_ctrl_chk #(
  parameter int NUM_DIGITS = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    clk_sel,
  input logic                    tick_out,
  input logic [1:0]              bright,
  input logic                    blank,
  input logic                    lamp_test,
  input logic [2:0]              font_row,
  input logic [6:0]              row_out,
  input logic [NUM_DIGITS*5-1:0] col_out
);
  AST_RESET_DARK: assert property (@(posedge clk)
    rst |=> (row_out == '0 && col_out == '0 && tick_out == 1'b0)); // R1

  AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_out)); // R2

  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (rst)
    font_row < 3'd7); // R2

  AST_DARK_STEP: assert property (@(posedge clk) disable iff (rst)
    (bright == 2'd0 && !lamp_test) |=> (col_out == '0)); // R4

  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (rst)
    (blank && !lamp_test) |=> (col_out == '0)); // R6

  AST_LAMP_LIT: assert property (@(posedge clk) disable iff (rst)
    lamp_test |=> (col_out == '1)); // R7

  AST_EXT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !clk_sel |=> !tick_out); // R9
endmodule

bind dmx_refresh_ctrl dmx_refresh_ctrl_chk #(.NUM_DIGITS(NUM_DIGITS)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .clk_sel   (clk_sel),
  .tick_out  (tick_out),
  .bright    (bright),
  .blank     (blank),
  .lamp_test (lamp_test),
  .font_row  (font_row),
  .row_out   (row_out),
  .col_out   (col_out)
);

// File: tb/dmx_refresh_ctrl_tb_top.sv
module dmx_refresh_ctrl_tb_top;
  localparam int ND  = 4;
  localparam int DIV = 4;
  localparam int BL  = 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clk_sel = 1'b1;
  logic          ext_clk_in = 1'b0;
  logic          tick_out;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [1:0]    bright = 2'd3;
  logic          blank = 1'b0;
  logic          lamp_test = 1'b0;
  logic [ND*7-1:0] font_code;
  logic [2:0]    font_row;
  logic [ND*5-1:0] font_cols;
  logic [6:0]    row_out;
  logic [ND*5-1:0] col_out;

  int errors = 0;
  int checks = 0;
  bit checking = 1'b0;
  string phase = "R1";

  always #10 clk = ~clk;

  dmx_refresh_ctrl #(.NUM_DIGITS(ND), .INT_DIV(DIV), .BLINK_LOG2(BL)) dut_i (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .ext_clk_in(ext_clk_in),
    .tick_out(tick_out), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bright(bright), .blank(blank), .lamp_test(lamp_test),
    .font_code(font_code), .font_row(font_row), .font_cols(font_cols),
    .row_out(row_out), .col_out(col_out)
  );

  // Arithmetic stand-in for the character pattern lookup
  function automatic logic [4:0] pat(input logic [6:0] c, input logic [2:0] r);
    return c[4:0] ^ {r[1:0], r} ^ c[6:2];
  endfunction

  always_comb begin
    for (int d = 0; d < ND; d++) font_cols[d*5 +: 5] = pat(font_code[d*7 +: 7], font_row);
  end

  // Reference model built from the requirements
  logic [7:0] mm [ND];
  int m_sub = 0, m_row = 0, m_frame = 0, m_div = 0;
  bit m_tick = 0, m_tko = 0, e1 = 0, e2 = 0, e3 = 0;
  logic [ND*5-1:0] exp_col = '0;
  logic [6:0] exp_row = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_sub = 0; m_row = 0; m_frame = 0; m_div = 0;
      m_tick = 0; m_tko = 0; e1 = 0; e2 = 0; e3 = 0;
      exp_col = '0; exp_row = '0;
    end else begin
      bit lit, boff;
      lit  = (bright == 2'd3) || (bright == 2'd2 && m_sub < 2) || (bright == 2'd1 && m_sub == 0);
      boff = ((m_frame >> BL) & 1) == 1;
      exp_row = 7'(1 << m_row);
      for (int d = 0; d < ND; d++) begin
        if (lamp_test) exp_col[d*5 +: 5] = 5'h1f;
        else if (blank || !lit || (mm[d][7] && boff)) exp_col[d*5 +: 5] = 5'h00;
        else exp_col[d*5 +: 5] = pat(mm[d][6:0], 3'(m_row));
      end
      if (m_tick) begin
        if (m_sub == 3) begin
          m_sub = 0;
          if (m_row == 6) begin m_row = 0; m_frame = (m_frame + 1) % (1 << (BL + 1)); end
          else m_row = m_row + 1;
        end else m_sub = m_sub + 1;
      end
      m_tick = clk_sel ? (m_div == DIV - 1) : (e2 && !e3);
      m_tko  = clk_sel && (m_div == DIV - 1);
      m_div  = clk_sel ? ((m_div == DIV - 1) ? 0 : m_div + 1) : 0;
      e3 = e2; e2 = e1; e1 = ext_clk_in;
    end
    if (wr_en) mm[wr_addr] = wr_data;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      chk(col_out == exp_col, {phase, " R3 col_out"}, 32'(col_out), 32'(exp_col));
      chk(row_out == exp_row, {phase, " R2 row_out"}, 32'(row_out), 32'(exp_row));
      chk(tick_out == m_tko, {phase, " R8 R9 tick_out"}, 32'(tick_out), 32'(m_tko));
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    int cnt;
    run(4);
    // R1: reset state at the ports
    chk(row_out == '0, "R1 reset row_out", 32'(row_out), 0);
    chk(col_out == '0, "R1 reset col_out", 32'(col_out), 0);
    chk(tick_out == 1'b0, "R1 reset tick_out", 32'(tick_out), 0);
    // R10: load characters, two of them blinking
    wr(0, 8'hC1); wr(1, 8'h62); wr(2, 8'hB5); wr(3, 8'h7A);
    @(negedge clk); rst = 1'b0; checking = 1'b1;
    phase = "R2 R10 steady"; run(500);
    for (int b = 0; b < 4; b++) begin
      @(negedge clk); bright = 2'(b); phase = "R4 brightness"; run(300);
    end
    @(negedge clk); bright = 2'd3; blank = 1'b1; phase = "R6 blank"; run(200);
    @(negedge clk); lamp_test = 1'b1; phase = "R7 lamp over blank"; run(200);
    @(negedge clk); blank = 1'b0; bright = 2'd0; phase = "R7 lamp over dark"; run(200);
    @(negedge clk); lamp_test = 1'b0; bright = 2'd2; phase = "R5 blink"; run(600);
    // R8: tick spacing
    cnt = 0;
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (tick_out) cnt++; end
    chk(cnt == 400 / DIV, "R8 tick count", 32'(cnt), 32'(400 / DIV));
    phase = "R10 rewrite"; wr(1, 8'hA3); wr(3, 8'h11); run(300);
    // R1: mid-run reset keeps stored characters
    @(negedge clk); rst = 1'b1; run(1);
    chk(row_out == '0 && col_out == '0, "R1 mid-run reset outputs", 32'(col_out), 0);
    run(2); rst = 1'b0; bright = 2'd3; phase = "R1 after reset"; run(300);
    // R9: external time base
    @(negedge clk); clk_sel = 1'b0; phase = "R9 external";
    cnt = 0;
    for (int i = 0; i < 900; i++) begin
      @(negedge clk);
      if (i % 3 == 0) ext_clk_in = ~ext_clk_in;
      if (tick_out) cnt++;
    end
    chk(cnt == 0, "R9 tick_out quiet", 32'(cnt), 0);
    @(negedge clk); ext_clk_in = 1'b1; phase = "R9 held high"; run(200);
    @(negedge clk); clk_sel = 1'b1; phase = "R8 back internal"; run(300);
    checking = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule